// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block sits on the host side of a successive-approximation converter that has a parallel result port. A free-running rate timer requests conversions. On each request the sequencer pulses the active-low convert-start line for a fixed number of clocks and then follows the converter's busy flag. It then fetches the 18-bit result through chip-select and read-strobe cycles. Depending on the selected bus width, it needs one, two or three strobes for this. Each completed result leaves the block as a one-cycle valid pulse with the word in two's complement form.

The result can be fetched in one of two orderings. In the first, the result is read as soon as busy falls, within the acquisition gap. In the second, the result is read during the next conversion, so the word delivered belongs to the previous conversion. A reset request aborts the converter and discards both the in-flight conversion and any result still waiting to be fetched. A power-down request lets the current conversion finish and be read, and stops new ones. A request from the timer that comes while the converter or the sequence is still busy is not issued; it is flagged as an overrun.

Top module: `sar_seq_top`

## Requirements
- R1: While and just after reset, convert-start, chip-select and read-strobe are high, and result-valid, overrun and the converter reset output are low.
- R2: Each conversion starts with convert-start driven low for exactly CNV_LOW cycles and then returned high. When the sequence keeps up, consecutive falling edges are period_i cycles apart.
- R3: A period_i below MIN_PERIOD is treated as MIN_PERIOD, so falling edges are never closer than MIN_PERIOD cycles.
- R4: Read-strobe is low only while chip-select is low and never while convert-start is low. Result bits are taken only in the cycle that ends a strobe, and only from the lane bits of that word.
- R5: bus_mode_i 2'b00 needs one read of adc_data_i[17:0]. 2'b01 needs two reads: adc_data_i[15:0] carries result bits 17:2, then adc_data_i[1:0] carries bits 1:0. 2'b10 or 2'b11 needs three reads on adc_data_i[7:0], in this order: bits 17:16 (in [1:0]), then 15:8, then 7:0.
- R6: res_data_o is two's complement. The raw MSB is inverted when straight_i is 1 or when bus_mode_i is 2'b00 (an 18-bit bus always carries straight binary). Otherwise the raw word is passed unchanged.
- R7: With rd_during_i low, each conversion is read after busy falls, and the sequencer returns to idle before the next request.
- R8: With rd_during_i high, a result is held until the next convert-start pulse and read while that conversion runs. The first conversion of a run produces no output.
- R9: abort_i high drives adc_rst_o high on the next cycle, releases all strobes, issues no conversion, and discards both the in-flight conversion and any held result.
- R10: While pd_i is high, adc_pd_o is high and timer requests are ignored without raising overrun. A conversion already started is completed and read.
- R11: A timer request while adc_busy_i is high or the sequence is not idle raises overrun_o for one cycle and issues no convert-start.
- R12: res_valid_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables the rate timer |
| period_i | input | PW | Conversion period in clock cycles |
| bus_mode_i | input | 2 | Bus width: 00 18-bit, 01 16-bit, 1x 8-bit |
| rd_during_i | input | 1 | 1: read the previous result during the next conversion |
| straight_i | input | 1 | Converter coding is straight binary (narrow buses) |
| pd_i | input | 1 | Power-down request |
| abort_i | input | 1 | Converter reset request |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_data_i | input | 18 | Converter parallel data bus |
| adc_cnv_no | output | 1 | Convert-start, active low |
| adc_cs_no | output | 1 | Chip-select, active low |
| adc_rd_no | output | 1 | Read strobe, active low |
| adc_rst_o | output | 1 | Converter reset |
| adc_pd_o | output | 1 | Converter power-down |
| res_valid_o | output | 1 | Result valid pulse |
| res_data_o | output | 18 | Result, two's complement |
| overrun_o | output | 1 | Dropped-request pulse |

## Verification
The converter model drives filler values on every bus bit outside the active lane, and also whenever the strobes are high. An engine that mis-masks a lane or samples one cycle late therefore returns a corrupted word. The samples include both extreme codes and zero, so a wrong MSB inversion is visible at once, in particular in 18-bit mode where straight_i must be ignored. In the read-during ordering, the reset request lands after a conversion has finished but before it was fetched. A sequencer that keeps the held word would then produce an output that no conversion accounts for. A converter slowed below the timer rate exercises the overrun path: a sequencer that issued anyway would pull convert-start low while busy is high.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W = 18;

    // Bus width selections
    localparam logic [1:0] BUS_FULL = 2'b00;
    localparam logic [1:0] BUS_WORD = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CNV  = 2'd1,
        ST_RD   = 2'd2,
        ST_WAIT = 2'd3
    } seq_st_e;

    // Index of the final strobe for a bus mode
    function automatic logic [1:0] last_word(input logic [1:0] mode);
        if (mode == BUS_FULL)      return 2'd0;
        else if (mode == BUS_WORD) return 2'd1;
        else                       return 2'd2;
    endfunction

    // Number of result bits carried by strobe idx, most significant first
    function automatic logic [4:0] lane_bits(input logic [1:0] mode, input logic [1:0] idx);
        if (mode == BUS_FULL)      return 5'(RES_W);
        else if (mode == BUS_WORD) return (idx == 2'd0) ? 5'd16 : 5'(RES_W - 16);
        else                       return (idx == 2'd0) ? 5'(RES_W - 16) : 5'd8;
    endfunction

endpackage

// File: rtl/sar_rate_timer.sv
module sar_rate_timer #(
    parameter int PW         = 16,
    parameter int MIN_PERIOD = 88
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic [PW-1:0] period_i,
    output logic          tick_o
);
    localparam logic [PW-1:0] MIN_P = PW'(MIN_PERIOD);

    logic [PW-1:0] eff_period;
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        eff_period = (period_i < MIN_P) ? MIN_P : period_i;
        tick_o     = run_i && (cnt_q >= eff_period - 1'b1);
        if (!run_i)      cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sar_rd_engine.sv
module sar_rd_engine
    import sar_seq_pkg::*;
#(
    parameter int RD_LOW = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [RES_W-1:0] data_i,
    output logic             cs_no,
    output logic             rd_no,
    output logic             done_o,
    output logic [RES_W-1:0] word_o
);
    localparam int CW = $clog2(RD_LOW + 1);

    typedef struct packed {
        logic             active;
        logic             low;
        logic [CW-1:0]    cnt;
        logic [1:0]       idx;
        logic [RES_W-1:0] acc;
        logic             done;
    } rd_s;

    rd_s q, d;
    logic [4:0]       lane_w;
    logic [RES_W-1:0] lane_mask;

    always_comb begin
        lane_w = lane_bits(mode_i, q.idx);
        for (int i = 0; i < RES_W; i++) lane_mask[i] = (i < int'(lane_w));

        d      = q;
        d.done = 1'b0;
        if (clear_i) begin
            d.active = 1'b0;
            d.low    = 1'b0;
        end else if (!q.active) begin
            if (start_i) begin
                d.active = 1'b1;
                d.low    = 1'b1;
                d.cnt    = CW'(RD_LOW - 1);
                d.idx    = 2'd0;
                d.acc    = '0;
            end
        end else if (q.low) begin
            if (q.cnt == '0) begin
                // Capture on the last strobe-low cycle, then release
                d.acc = (q.acc << lane_w) | (data_i & lane_mask);
                d.low = 1'b0;
                if (q.idx == last_word(mode_i)) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.idx = q.idx + 2'd1;
                end
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end else begin
            // One-cycle gap with chip-select held, then next strobe
            d.low = 1'b1;
            d.cnt = CW'(RD_LOW - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cs_no  = ~q.active;
    assign rd_no  = ~q.low;
    assign done_o = q.done;
    assign word_o = q.acc;

endmodule

// File: rtl/sar_code_map.sv
module sar_code_map
    import sar_seq_pkg::*;
(
    input  logic [1:0]       mode_i,
    input  logic             straight_i,
    input  logic [RES_W-1:0] raw_i,
    output logic [RES_W-1:0] tc_o
);
    logic flip_msb;

    always_comb begin
        flip_msb = (mode_i == BUS_FULL) || straight_i;
        tc_o     = {raw_i[RES_W-1] ^ flip_msb, raw_i[RES_W-2:0]};
    end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int PW         = 16,
    parameter int MIN_PERIOD = 88,
    parameter int CNV_LOW    = 2,
    parameter int RD_LOW     = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PW-1:0]    period_i,
    input  logic [1:0]       bus_mode_i,
    input  logic             rd_during_i,
    input  logic             straight_i,
    input  logic             pd_i,
    input  logic             abort_i,
    input  logic             adc_busy_i,
    input  logic [RES_W-1:0] adc_data_i,
    output logic             adc_cnv_no,
    output logic             adc_cs_no,
    output logic             adc_rd_no,
    output logic             adc_rst_o,
    output logic             adc_pd_o,
    output logic             res_valid_o,
    output logic [RES_W-1:0] res_data_o,
    output logic             overrun_o
);
    localparam int CCW = $clog2(CNV_LOW + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [CCW-1:0]   cnt;
        logic             seen;
        logic             pending;
        logic             rd_after;
        logic             cnv_low;
        logic             valid;
        logic [RES_W-1:0] data;
        logic             ovr;
        logic             rst_o;
        logic             pd_o;
    } seq_s;

    seq_s             q, d;
    logic             tick, rd_start, rd_done;
    logic [RES_W-1:0] rd_word, tc_word;

    sar_rate_timer #(.PW(PW), .MIN_PERIOD(MIN_PERIOD)) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .period_i (period_i),
        .tick_o   (tick)
    );

    sar_rd_engine #(.RD_LOW(RD_LOW)) rd_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (abort_i),
        .start_i (rd_start),
        .mode_i  (bus_mode_i),
        .data_i  (adc_data_i),
        .cs_no   (adc_cs_no),
        .rd_no   (adc_rd_no),
        .done_o  (rd_done),
        .word_o  (rd_word)
    );

    sar_code_map map_i (
        .mode_i     (bus_mode_i),
        .straight_i (straight_i),
        .raw_i      (rd_word),
        .tc_o       (tc_word)
    );

    always_comb begin
        d        = q;
        rd_start = 1'b0;
        d.valid  = 1'b0;
        d.ovr    = 1'b0;
        d.rst_o  = abort_i;
        d.pd_o   = pd_i;
        if (adc_busy_i) d.seen = 1'b1;

        if (abort_i) begin
            d.st      = ST_IDLE;
            d.cnv_low = 1'b0;
            d.pending = 1'b0;
            d.seen    = 1'b0;
        end else begin
            if (tick && !pd_i && q.st != ST_IDLE) d.ovr = 1'b1;
            case (q.st)
                ST_IDLE: begin
                    if (tick && !pd_i) begin
                        if (adc_busy_i) begin
                            d.ovr = 1'b1;
                        end else begin
                            d.cnv_low = 1'b1;
                            d.cnt     = CCW'(CNV_LOW - 1);
                            d.seen    = 1'b0;
                            d.st      = ST_CNV;
                        end
                    end
                end
                ST_CNV: begin
                    if (q.cnt == '0) begin
                        d.cnv_low = 1'b0;
                        if (rd_during_i && q.pending) begin
                            d.st       = ST_RD;
                            d.rd_after = 1'b0;
                            rd_start   = 1'b1;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (q.seen && !adc_busy_i) begin
                        if (rd_during_i) begin
                            d.pending = 1'b1;
                            d.st      = ST_IDLE;
                        end else begin
                            d.st       = ST_RD;
                            d.rd_after = 1'b1;
                            rd_start   = 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (rd_done) begin
                        d.valid   = 1'b1;
                        d.data    = tc_word;
                        d.pending = 1'b0;
                        d.st      = q.rd_after ? ST_IDLE : ST_WAIT;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign adc_cnv_no  = ~q.cnv_low;
    assign adc_rst_o   = q.rst_o;
    assign adc_pd_o    = q.pd_o;
    assign res_valid_o = q.valid;
    assign res_data_o  = q.data;
    assign overrun_o   = q.ovr;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic adc_busy_i,
    input logic adc_cnv_no,
    input logic adc_cs_no,
    input logic adc_rd_no,
    input logic adc_rst_o,
    input logic adc_pd_o,
    input logic res_valid_o,
    input logic overrun_o
);

    assert_no_cnv_while_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(adc_cnv_no) |-> !$past(adc_busy_i));

    assert_ovr_not_issued_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |-> !$fell(adc_cnv_no));

    assert_rd_inside_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adc_rd_no |-> !adc_cs_no);

    assert_rd_apart_from_cnv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adc_rd_no |-> adc_cnv_no);

    assert_valid_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |=> !res_valid_o);

    assert_abort_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_rst_o |-> (adc_cs_no && adc_cnv_no));

    assert_pd_blocks_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adc_pd_o |-> !$fell(adc_cnv_no));

endmodule

bind sar_seq_top sar_seq_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adc_busy_i  (adc_busy_i),
    .adc_cnv_no  (adc_cnv_no),
    .adc_cs_no   (adc_cs_no),
    .adc_rd_no   (adc_rd_no),
    .adc_rst_o   (adc_rst_o),
    .adc_pd_o    (adc_pd_o),
    .res_valid_o (res_valid_o),
    .overrun_o   (overrun_o)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
    localparam int MINP = 88;
    localparam int CNVL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] period = 16'd100;
    logic [1:0]  bus_mode = 2'b00;
    logic        during = 1'b0;
    logic        straight = 1'b0;
    logic        pd = 1'b0;
    logic        abort = 1'b0;
    logic        busy = 1'b0;
    logic [17:0] data;
    logic        cnv_n, cs_n, rd_n, adc_rst, adc_pd, res_valid, ovr;
    logic [17:0] res_data;

    always #10 clk = ~clk;

    sar_seq_top #(.PW(16), .MIN_PERIOD(MINP), .CNV_LOW(CNVL), .RD_LOW(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .period_i(period),
        .bus_mode_i(bus_mode), .rd_during_i(during), .straight_i(straight),
        .pd_i(pd), .abort_i(abort), .adc_busy_i(busy), .adc_data_i(data),
        .adc_cnv_no(cnv_n), .adc_cs_no(cs_n), .adc_rd_no(rd_n),
        .adc_rst_o(adc_rst), .adc_pd_o(adc_pd), .res_valid_o(res_valid),
        .res_data_o(res_data), .overrun_o(ovr)
    );

    int     n_chk = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard
    logic [17:0] exp_q[$];
    task automatic push_expected(input logic [17:0] s);
        exp_q.push_back(s);
    endtask

    function automatic logic [17:0] sample_of(input int k);
        case (k % 6)
            0: return 18'h20000;
            1: return 18'h1FFFF;
            2: return 18'h00000;
            3: return 18'h3FFFF;
            default: return 18'((k * 40503 + 12345) ^ (k << 9));
        endcase
    endfunction

    function automatic logic [17:0] raw_of(input logic [17:0] s);
        return (bus_mode == 2'b00 || straight) ? (s ^ 18'h20000) : s;
    endfunction

    function automatic int words_of(input logic [1:0] m);
        return (m == 2'b00) ? 1 : ((m == 2'b01) ? 2 : 3);
    endfunction

    // Converter model
    int          conv_len = 70;
    int          m_cnt = 0;
    int          samp_idx = 0;
    logic        m_cnv_q = 1'b1;
    logic        m_rd_q = 1'b1;
    logic [17:0] m_cur = '0;
    logic [17:0] latest_raw = '0;
    int          rd_idx = 0;

    always @(posedge clk) begin
        m_cnv_q <= cnv_n;
        m_rd_q  <= rd_n;
        if (cs_n) rd_idx <= 0;
        else if (!m_rd_q && rd_n) rd_idx <= rd_idx + 1;
        if (adc_rst) begin
            busy  <= 1'b0;
            m_cnt <= 0;
        end else if (m_cnv_q && !cnv_n && !busy) begin
            busy     <= 1'b1;
            m_cnt    <= conv_len;
            m_cur    <= sample_of(samp_idx);
            samp_idx <= samp_idx + 1;
        end else if (busy) begin
            if (m_cnt <= 1) begin
                busy       <= 1'b0;
                latest_raw <= raw_of(m_cur);
                push_expected(m_cur);
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    always_comb begin
        if (!cs_n && !rd_n) begin
            case (bus_mode)
                2'b00: data = latest_raw;
                2'b01: data = (rd_idx == 0) ? {2'b11, latest_raw[17:2]}
                                            : {16'hFFFF, latest_raw[1:0]};
                default: data = (rd_idx == 0) ? {10'h3FF, 6'b0, latest_raw[17:16]}
                              : (rd_idx == 1) ? {10'h3FF, latest_raw[15:8]}
                                              : {10'h3FF, latest_raw[7:0]};
            endcase
        end else begin
            data = 18'h15555;
        end
    end

    // Monitor
    string  tag = "R6 R7";
    bit     chk_period = 1'b0;
    int     exp_period = 100;
    bit     have_last = 1'b0;
    longint last_fall = 0;
    int     falls = 0, n_valid = 0, n_ovr = 0, low_len = 0, rd_falls = 0;
    logic   p_cnv = 1'b1, p_rd = 1'b1, p_cs = 1'b1, p_valid = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cnv && !cnv_n) begin
                falls++;
                check(!busy, "R11 start while busy", busy, 0);
                if (chk_period && have_last)
                    check(cyc - last_fall == exp_period, "R2/R3 start spacing",
                          cyc - last_fall, exp_period);
                last_fall = cyc;
                have_last = 1'b1;
            end
            if (!cnv_n) low_len++;
            if (!p_cnv && cnv_n) begin
                check(low_len == CNVL, "R2 start pulse width", low_len, CNVL);
                low_len = 0;
            end
            if (p_rd && !rd_n) rd_falls++;
            if (!p_cs && cs_n) begin
                check(rd_falls == words_of(bus_mode), "R5 strobes per result",
                      rd_falls, words_of(bus_mode));
                rd_falls = 0;
            end
            if (res_valid) begin
                n_valid++;
                check(!p_valid, "R12 valid width", p_valid, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8/R9 result with no conversion", res_data, 0);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    check(res_data == e, tag, res_data, e);
                end
            end
            if (ovr) n_ovr++;
        end
        p_cnv   = cnv_n;
        p_rd    = rd_n;
        p_cs    = cs_n;
        p_valid = res_valid;
    end

    task automatic run_convs(input int n);
        int base;
        base = falls;
        run  = 1'b1;
        while (falls < base + n) @(negedge clk);
    endtask

    task automatic stop_and_drain(input int leftover, input string req);
        run = 1'b0;
        repeat (400) @(negedge clk);
        check(exp_q.size() == leftover, req, exp_q.size(), leftover);
        exp_q.delete();
        have_last = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int v0, o0, f0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(cnv_n && cs_n && rd_n, "R1 strobes in reset", {cnv_n, cs_n, rd_n}, 3'b111);
        check(!res_valid && !ovr && !adc_rst, "R1 flags in reset", {res_valid, ovr, adc_rst}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(cnv_n && cs_n && rd_n, "R1 strobes after reset", {cnv_n, cs_n, rd_n}, 3'b111);
        check(!res_valid && !ovr && !adc_rst, "R1 flags after reset", {res_valid, ovr, adc_rst}, 0);

        // 18-bit bus, read after conversion; straight_i must be ignored
        chk_period = 1'b1; exp_period = 100; period = 16'd100;
        bus_mode = 2'b00; straight = 1'b0; tag = "R4 R6 R7 full-width read";
        v0 = n_valid;
        run_convs(6);
        stop_and_drain(0, "R7 all results read");
        check(n_valid - v0 == 6, "R7 result count", n_valid - v0, 6);

        // 16-bit bus, straight binary
        period = 16'd120; exp_period = 120;
        bus_mode = 2'b01; straight = 1'b1; tag = "R5 R6 two-word read";
        run_convs(5);
        stop_and_drain(0, "R5 two-word drain");

        // 8-bit bus, two's complement
        period = 16'd95; exp_period = 95;
        bus_mode = 2'b10; straight = 1'b0; tag = "R5 R6 byte read";
        run_convs(5);
        stop_and_drain(0, "R5 byte drain");

        // Period below limit is clamped
        period = 16'd10; exp_period = MINP;
        bus_mode = 2'b11; straight = 1'b1; tag = "R3 R6 clamped rate";
        run_convs(5);
        stop_and_drain(0, "R3 clamped drain");

        // Read during the next conversion
        period = 16'd100; exp_period = 100;
        during = 1'b1; bus_mode = 2'b10; straight = 1'b1; tag = "R8 deferred read";
        v0 = n_valid;
        run_convs(5);
        stop_and_drain(1, "R8 last result still held");
        check(n_valid - v0 == 4, "R8 deferred count", n_valid - v0, 4);
        during = 1'b0;

        // Converter slower than the timer
        chk_period = 1'b0; conv_len = 150; bus_mode = 2'b00; tag = "R11 results under overrun";
        o0 = n_ovr;
        run_convs(4);
        stop_and_drain(0, "R11 drain");
        check(n_ovr - o0 > 0, "R11 overrun flagged", n_ovr - o0, 1);
        conv_len = 70;

        // Power-down lets the current conversion finish
        tag = "R10 final result";
        v0 = n_valid; o0 = n_ovr; f0 = falls;
        run_convs(1);
        pd = 1'b1;
        repeat (400) @(negedge clk);
        check(falls - f0 == 1, "R10 no start in power-down", falls - f0, 1);
        check(n_valid - v0 == 1, "R10 current result read", n_valid - v0, 1);
        check(n_ovr == o0, "R10 no overrun in power-down", n_ovr - o0, 0);
        check(adc_pd, "R10 power-down output", adc_pd, 1);
        pd = 1'b0;
        stop_and_drain(0, "R10 drain");

        // Abort mid-conversion, read after conversion
        tag = "R9 after abort";
        v0 = n_valid;
        run_convs(1);
        repeat (10) @(negedge clk);
        abort = 1'b1; run = 1'b0;
        exp_q.delete();
        @(negedge clk);
        check(adc_rst, "R9 reset output", adc_rst, 1);
        check(cs_n && cnv_n, "R9 strobes released", {cs_n, cnv_n}, 2'b11);
        repeat (2) @(negedge clk);
        abort = 1'b0;
        repeat (300) @(negedge clk);
        check(n_valid == v0, "R9 aborted result dropped", n_valid - v0, 0);
        check(!adc_rst, "R9 reset released", adc_rst, 0);
        stop_and_drain(0, "R9 drain");

        // Abort with a held result in deferred mode
        during = 1'b1; bus_mode = 2'b01; straight = 1'b0;
        run_convs(3);
        repeat (90) @(negedge clk);
        abort = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        abort = 1'b0;
        exp_q.delete();
        repeat (20) @(negedge clk);
        v0 = n_valid;
        tag = "R8 R9 held result discarded";
        run_convs(2);
        stop_and_drain(1, "R9 deferred drain");
        check(n_valid - v0 == 1, "R9 held result not delivered", n_valid - v0, 1);

        finish_run();
    end

endmodule